// File: doc/BRIEF.md
# Per-Core Banked Timer Register Router

This block sits between a shared register bus and a bank of per-core timer and watchdog slices. Every core owns two slices, a timer and a watchdog, so a router configured for N cores (1 to 4) serves 2×N slices. Slice s belongs to core s/2 and is that core's timer when s is even and its watchdog when s is odd. Each request carries a core identifier. A core reaches its own pair through two alias windows that are steered by that identifier. Any core can also reach any slice through a fixed window that does not depend on who is asking.

The address is split into a window number (bits above bit 4) and a 5-bit byte offset that passes straight to the selected slice. Windows are 32 bytes apart. Window 0 is the requester's timer and window 1 is the requester's watchdog. Window 2+s is slice s. A request is rejected when the core identifier is not configured, the window is unmapped, or the access is not a full word. A rejected request selects no slice, returns zero and raises a one-cycle error flag.

The slices' interrupt lines come out as one ordered vector. The router also fans a common reset out to every slice. That reset is asserted asynchronously and released synchronously.

Top module: `core_slice_router`

## Requirements
- R1: A valid request to window 0 (address bits above bit 4 equal 0) from core c selects only slice 2c, the timer of core c.
- R2: A valid request to window 1 from core c selects only slice 2c+1, the watchdog of core c.
- R3: A valid request to window w, with 2 ≤ w < 2N+2, selects only slice w−2, whatever the requesting core is. Address bits [4:0] appear unchanged on `slc_offs`.
- R4: One clock after a request is accepted, `rsp_rdata` holds the read data that the selected slice presented during the request cycle. A write returns zero. `rsp_rdata` changes only in cycles that follow a request.
- R5: At most one bit of `slc_sel` is high at any time. `slc_write` is high only together with a selected slice. Without `req_valid`, no slice is selected. `slc_wdata` carries `req_wdata` unchanged.
- R6: A request whose core identifier is N or greater selects no slice and writes nothing. One clock later it gives `rsp_rdata` = 0 and `rsp_err` = 1.
- R7: A request to an unmapped window (w ≥ 2N+2) behaves as in R6.
- R8: A request whose `req_size` is not 2'b10 (the 4-byte size code) behaves as in R6.
- R9: `irq_out[2c]` follows the timer interrupt of core c, `slc_irq[2c]`. `irq_out[2c+1]` follows the watchdog interrupt of core c, `slc_irq[2c+1]`. Both follow without a clock delay.
- R10: All bits of `slc_rst_n` fall together as soon as `rst_n` is low. All bits rise together on the second rising clock edge after `rst_n` goes high. Every slice is reset, whether or not it has been accessed.
- R11: During reset, `rsp_rdata` = 0 and `rsp_err` = 0. `rsp_err` is high only in the cycle after a rejected request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 2 | Identifier of the requesting core |
| req_addr | input | ADDR_W | Byte address: window number above bit 4, offset in bits [4:0] |
| req_size | input | 2 | Access size code; 2'b10 = 4 bytes |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle flag for a rejected request |
| slc_rst_n | output | 2×NUM_CORES | Reset to every slice |
| slc_sel | output | 2×NUM_CORES | One-hot slice select |
| slc_write | output | 1 | Write strobe to the selected slice |
| slc_offs | output | 5 | Byte offset inside the slice |
| slc_wdata | output | 32 | Write data to the slices |
| slc_rdata | input | 64×NUM_CORES | Read data from the slices, 32 bits per slice, slice 0 lowest |
| slc_irq | input | 2×NUM_CORES | Interrupt lines from the slices |
| irq_out | output | 2×NUM_CORES | Ordered interrupt vector |

## Verification
Several properties are checked on every cycle:
- the select is one-hot or empty;
- nothing is selected without a request;
- the alias windows steer to slices 2c and 2c+1;
- a bad core identifier or bad size leads to an error with zero data;
- the error flag never appears without a request one cycle earlier;
- the slice resets move together.

Other behaviour can only be shown by the bench's scenarios, where a write through one window is read back through another:
- that data reaches the right slice;
- that a rejected write leaves every slice unchanged;
- that the fixed windows ignore the requester;
- that a mid-run reset clears all slices;
- the release timing of the reset.

// File: rtl/csr_rt_pkg.sv
package csr_rt_pkg;
  localparam int MAX_CORES = 4;
  localparam int CORE_W    = $clog2(MAX_CORES);
  localparam int IDX_W     = CORE_W + 1;
  localparam int WORD_W    = 32;
  localparam int OFFS_W    = 5;
  localparam logic [1:0] SIZE_WORD = 2'b10;

  typedef struct packed {
    logic             hit;
    logic             bad;
    logic [IDX_W-1:0] idx;
  } route_t;
endpackage

// File: rtl/router_rst_sync.sv
module router_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/router_decode.sv
module router_decode
  import csr_rt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int WIN_W     = 7,
  localparam int NSLICE   = 2 * NUM_CORES
) (
  input  logic              req_valid,
  input  logic [CORE_W-1:0] req_core,
  input  logic [WIN_W-1:0]  req_win,
  input  logic [1:0]        req_size,
  output route_t            route,
  output logic [NSLICE-1:0] sel
);
  localparam logic [CORE_W:0] CORE_LIM = (CORE_W+1)'(NUM_CORES);
  localparam logic [WIN_W:0]  WIN_LIM  = (WIN_W+1)'(NSLICE + 2);

  logic             core_ok;
  logic             win_ok;
  logic             size_ok;
  logic             is_alias;
  logic [IDX_W-1:0] alias_idx;
  logic [IDX_W-1:0] fixed_idx;

  always_comb begin
    core_ok   = ({1'b0, req_core} < CORE_LIM);
    win_ok    = ({1'b0, req_win} < WIN_LIM);
    size_ok   = (req_size == SIZE_WORD);
    is_alias  = (req_win[WIN_W-1:1] == '0);
    alias_idx = {req_core, req_win[0]};
    fixed_idx = req_win[IDX_W-1:0] - IDX_W'(2);
    route.hit = req_valid && core_ok && win_ok && size_ok;
    route.bad = req_valid && !(core_ok && win_ok && size_ok);
    route.idx = is_alias ? alias_idx : fixed_idx;
  end

  for (genvar s = 0; s < NSLICE; s++) begin : g_sel
    assign sel[s] = route.hit && (route.idx == IDX_W'(s));
  end
endmodule

// File: rtl/router_rdmux.sv
module router_rdmux
  import csr_rt_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic [NSLICE-1:0]        sel,
  input  logic [NSLICE*WORD_W-1:0] rdata_flat,
  output logic [WORD_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int s = 0; s < NSLICE; s++) begin
      if (sel[s]) begin
        rdata = rdata | rdata_flat[s*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/router_irq_order.sv
module router_irq_order #(
  parameter int NUM_CORES = 2,
  localparam int NSLICE   = 2 * NUM_CORES
) (
  input  logic [NSLICE-1:0] slc_irq,
  output logic [NSLICE-1:0] irq_out
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic tmr_irq;
    logic wdg_irq;
    assign tmr_irq          = slc_irq[2*c];
    assign wdg_irq          = slc_irq[2*c+1];
    assign irq_out[2*c]     = tmr_irq;
    assign irq_out[2*c+1]   = wdg_irq;
  end
endmodule

// File: rtl/core_slice_router.sv
module core_slice_router
  import csr_rt_pkg::*;
#(
  parameter int  NUM_CORES = 2,
  parameter int  ADDR_W    = 12,
  localparam int NSLICE    = 2 * NUM_CORES,
  localparam int WIN_W     = ADDR_W - OFFS_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic [CORE_W-1:0]        req_core,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_size,
  input  logic [WORD_W-1:0]        req_wdata,
  output logic [WORD_W-1:0]        rsp_rdata,
  output logic                     rsp_err,
  output logic [NSLICE-1:0]        slc_rst_n,
  output logic [NSLICE-1:0]        slc_sel,
  output logic                     slc_write,
  output logic [OFFS_W-1:0]        slc_offs,
  output logic [WORD_W-1:0]        slc_wdata,
  input  logic [NSLICE*WORD_W-1:0] slc_rdata,
  input  logic [NSLICE-1:0]        slc_irq,
  output logic [NSLICE-1:0]        irq_out
);
  route_t              route;
  logic                srst_n;
  logic [WORD_W-1:0]   mux_rdata;
  logic [WORD_W-1:0]   rdata_d;
  logic                err_d;
  logic                rsp_en;

  router_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  router_decode #(.NUM_CORES(NUM_CORES), .WIN_W(WIN_W)) u_dec (
    .req_valid (req_valid),
    .req_core  (req_core),
    .req_win   (req_addr[ADDR_W-1:OFFS_W]),
    .req_size  (req_size),
    .route     (route),
    .sel       (slc_sel)
  );

  router_rdmux #(.NSLICE(NSLICE)) u_mux (
    .sel        (slc_sel),
    .rdata_flat (slc_rdata),
    .rdata      (mux_rdata)
  );

  router_irq_order #(.NUM_CORES(NUM_CORES)) u_irq (
    .slc_irq (slc_irq),
    .irq_out (irq_out)
  );

  assign slc_rst_n = {NSLICE{srst_n}};
  assign slc_write = route.hit && req_write;
  assign slc_offs  = req_addr[OFFS_W-1:0];
  assign slc_wdata = req_wdata;

  always_comb begin
    rsp_en  = req_valid;
    err_d   = route.bad;
    rdata_d = (route.hit && !req_write) ? mux_rdata : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_err <= err_d;
      if (rsp_en) begin
        rsp_rdata <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/core_slice_router_chk.sv
module core_slice_router_chk
  import csr_rt_pkg::*;
#(
  parameter int  NUM_CORES = 2,
  parameter int  ADDR_W    = 12,
  localparam int NSLICE    = 2 * NUM_CORES
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_write,
  input logic [CORE_W-1:0]   req_core,
  input logic [ADDR_W-1:0]   req_addr,
  input logic [1:0]          req_size,
  input logic [WORD_W-1:0]   rsp_rdata,
  input logic                rsp_err,
  input logic [NSLICE-1:0]   slc_rst_n,
  input logic [NSLICE-1:0]   slc_sel,
  input logic                slc_write
);
  logic live;
  logic good_core;
  logic good_size;
  logic [ADDR_W-OFFS_W-1:0] win;

  assign live      = rst_n && slc_rst_n[0];
  assign good_core = int'(req_core) < NUM_CORES;
  assign good_size = (req_size == SIZE_WORD);
  assign win       = req_addr[ADDR_W-1:OFFS_W];

  // R5
  a_r5_one_slice: assert property (@(posedge clk) disable iff (!live)
    $onehot0(slc_sel));
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!live)
    !req_valid |-> (slc_sel == '0 && !slc_write));
  a_r5_write_needs_sel: assert property (@(posedge clk) disable iff (!live)
    slc_write |-> (slc_sel != '0));
  // R1
  a_r1_alias_timer: assert property (@(posedge clk) disable iff (!live)
    (req_valid && win == '0 && good_core && good_size)
      |-> (slc_sel == (NSLICE'(1) << (2 * int'(req_core)))));
  // R2
  a_r2_alias_wdog: assert property (@(posedge clk) disable iff (!live)
    (req_valid && win == 1 && good_core && good_size)
      |-> (slc_sel == (NSLICE'(1) << (2 * int'(req_core) + 1))));
  // R6
  a_r6_bad_core_nosel: assert property (@(posedge clk) disable iff (!live)
    (req_valid && !good_core) |-> (slc_sel == '0));
  a_r6_bad_core_resp: assert property (@(posedge clk) disable iff (!live)
    (req_valid && !good_core) |=> (rsp_err && rsp_rdata == '0));
  // R8
  a_r8_bad_size_resp: assert property (@(posedge clk) disable iff (!live)
    (req_valid && !good_size) |=> (rsp_err && rsp_rdata == '0));
  // R11
  a_r11_err_needs_req: assert property (@(posedge clk) disable iff (!live)
    rsp_err |-> $past(req_valid));
  // R10
  a_r10_rst_together: assert property (@(posedge clk)
    ($countones(slc_rst_n) == 0) || ($countones(slc_rst_n) == NSLICE));
endmodule

bind core_slice_router core_slice_router_chk #(
  .NUM_CORES (NUM_CORES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_core  (req_core),
  .req_addr  (req_addr),
  .req_size  (req_size),
  .rsp_rdata (rsp_rdata),
  .rsp_err   (rsp_err),
  .slc_rst_n (slc_rst_n),
  .slc_sel   (slc_sel),
  .slc_write (slc_write)
);

// File: tb/core_slice_router_test.sv
`timescale 1ns/1ps
module core_slice_router_test;
  localparam int NC  = 3;
  localparam int AW  = 12;
  localparam int NSL = 2 * NC;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [1:0]        req_core;
  logic [AW-1:0]     req_addr;
  logic [1:0]        req_size;
  logic [31:0]       req_wdata;
  logic [31:0]       rsp_rdata;
  logic              rsp_err;
  logic [NSL-1:0]    slc_rst_n;
  logic [NSL-1:0]    slc_sel;
  logic              slc_write;
  logic [4:0]        slc_offs;
  logic [31:0]       slc_wdata;
  logic [NSL*32-1:0] slc_rdata;
  logic [NSL-1:0]    slc_irq;
  logic [NSL-1:0]    irq_out;

  int checks;
  int errors;
  logic [31:0] exp_mem [NSL][8];

  core_slice_router #(.NUM_CORES(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .slc_rst_n(slc_rst_n), .slc_sel(slc_sel), .slc_write(slc_write),
    .slc_offs(slc_offs), .slc_wdata(slc_wdata), .slc_rdata(slc_rdata),
    .slc_irq(slc_irq), .irq_out(irq_out)
  );

  // Register stubs standing in for the timer and watchdog slices
  for (genvar s = 0; s < NSL; s++) begin : g_stub
    logic [31:0] mem [8];
    always_ff @(posedge clk or negedge slc_rst_n[s]) begin
      if (!slc_rst_n[s]) begin
        for (int i = 0; i < 8; i++) mem[i] <= '0;
      end else if (slc_sel[s] && slc_write) begin
        mem[slc_offs[4:2]] <= slc_wdata;
      end
    end
    assign slc_rdata[s*32 +: 32] = mem[slc_offs[4:2]];
  end

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_slice(int core, int win, int size);
    if (size != 2 || core >= NC || win >= NSL + 2) return -1;
    if (win == 0) return 2 * core;
    if (win == 1) return 2 * core + 1;
    return win - 2;
  endfunction

  function automatic string tag_of(int core, int win, int size);
    if (size != 2) return "R8";
    if (core >= NC) return "R6";
    if (win >= NSL + 2) return "R7";
    if (win == 0) return "R1";
    if (win == 1) return "R2";
    return "R3";
  endfunction

  function automatic void clear_model();
    for (int s = 0; s < NSL; s++)
      for (int i = 0; i < 8; i++) exp_mem[s][i] = '0;
  endfunction

  task automatic access(input bit wr, input int core, input int win,
                        input int offs, input int size, input logic [31:0] data);
    int s;
    string tg;
    logic [31:0] expv;
    logic [NSL-1:0] exp_sel;
    @(negedge clk);
    chk(rsp_err == 1'b0, "R11 idle err", {31'b0, rsp_err}, 32'h0);
    s  = exp_slice(core, win, size);
    tg = tag_of(core, win, size);
    req_valid = 1'b1;
    req_write = wr;
    req_core  = 2'(core);
    req_addr  = AW'(win * 32 + offs);
    req_size  = 2'(size);
    req_wdata = data;
    #1;
    exp_sel = (s >= 0) ? NSL'(1) << s : '0;
    chk(slc_sel == exp_sel, {tg, " select"}, 32'(slc_sel), 32'(exp_sel));
    chk(slc_write == (wr && s >= 0), "R5 write strobe", {31'b0, slc_write},
        {31'b0, wr && s >= 0});
    if (s >= 0) begin
      chk(slc_offs == 5'(offs), "R3 offset", 32'(slc_offs), 32'(offs));
      chk(slc_wdata == data, "R5 wdata", slc_wdata, data);
    end
    expv = (s >= 0 && !wr) ? exp_mem[s][offs / 4] : '0;
    @(posedge clk);
    if (wr && s >= 0) exp_mem[s][offs / 4] = data;
    @(negedge clk);
    chk(rsp_rdata == expv, (s >= 0) ? "R4 rdata" : {tg, " rdata"}, rsp_rdata, expv);
    chk(rsp_err == (s < 0), {tg, " err"}, {31'b0, rsp_err}, {31'b0, s < 0});
    req_valid = 1'b0;
    req_write = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(slc_rst_n == '0, "R10 assert async", 32'(slc_rst_n), 32'h0);
    chk(rsp_err == 1'b0 && rsp_rdata == '0, "R11 reset state", rsp_rdata, 32'h0);
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(slc_rst_n == '0, "R10 held one edge", 32'(slc_rst_n), 32'h0);
    @(posedge clk);
    @(negedge clk);
    chk(slc_rst_n == '1, "R10 released", 32'(slc_rst_n), 32'(NSL'('1)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", checks, -1);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_core = '0;
    req_addr = '0;
    req_size = 2'b10;
    req_wdata = '0;
    slc_irq = '0;
    clear_model();
    void'($urandom(32'd20240611));
    do_reset();

    // Fixed windows, each slice tagged with a distinct value (R3)
    for (int s = 0; s < NSL; s++) access(1, s % NC, s + 2, 4, 2, 32'hA000_0000 + s);
    // Alias windows from every core read back (R1, R2)
    for (int c = 0; c < NC; c++) begin
      access(0, c, 0, 4, 2, 0);
      access(0, c, 1, 4, 2, 0);
    end
    // Alias writes then readback through the fixed window (R1, R2, R3)
    for (int c = 0; c < NC; c++) begin
      access(1, c, 0, 28, 2, 32'h7100_0000 + c);
      access(1, c, 1, 0, 2, 32'h7200_0000 + c);
      access(0, (c + 1) % NC, 2 + 2 * c, 28, 2, 0);
      access(0, (c + 2) % NC, 3 + 2 * c, 0, 2, 0);
    end
    // Rejected writes must leave every slice untouched (R6, R7, R8)
    access(1, 3, 0, 4, 2, 32'hDEAD_0001);
    access(1, 3, 2, 4, 2, 32'hDEAD_0002);
    access(1, 0, NSL + 2, 4, 2, 32'hDEAD_0003);
    access(1, 1, 127, 4, 2, 32'hDEAD_0004);
    access(1, 0, 2, 4, 1, 32'hDEAD_0005);
    access(1, 0, 0, 4, 0, 32'hDEAD_0006);
    access(0, 0, 2, 4, 3, 0);
    for (int s = 0; s < NSL; s++) access(0, 0, s + 2, 4, 2, 0);

    // Interrupt ordering (R9)
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      slc_irq = NSL'($urandom);
      #1;
      for (int c = 0; c < NC; c++) begin
        chk(irq_out[2*c] == slc_irq[2*c], "R9 timer irq", 32'(irq_out), 32'(slc_irq));
        chk(irq_out[2*c+1] == slc_irq[2*c+1], "R9 wdog irq", 32'(irq_out), 32'(slc_irq));
      end
    end

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int core, win, size, offs;
      core = $urandom_range(0, 3);
      win  = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 127) : $urandom_range(0, NSL + 3);
      size = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 3) : 2;
      offs = $urandom_range(0, 7) * 4;
      access($urandom_range(0, 1) == 1, core, win, offs, size, $urandom);
    end

    // Mid-run reset clears every slice (R10)
    do_reset();
    for (int s = 0; s < NSL; s++)
      for (int i = 0; i < 8; i++) access(0, 0, s + 2, i * 4, 2, 0);

    @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule